// File: doc/BRIEF.md
# Misaligned Transfer Bus Cycle Splitter

This block turns one data-transfer request into a short run of aligned accesses on a 32-bit big-endian bus. A request gives a start address, a size (byte, word or longword), a direction and, for writes, the value to store. The block chooses how to divide the transfer from the size and the two low address bits. It then issues each piece with its own address and access size, and waits for an acknowledge before it moves to the next piece.

For writes the block cuts the value into pieces and puts each piece on the byte lanes that belong to its address. For reads it takes each piece from its lanes and builds the full value, with the lowest address as the most significant byte. A one-cycle done pulse follows the last acknowledge. Source reads and destination writes are separate requests, so each one is divided by its own address.

Top module: `xfer_splitter`

## Requirements
- R1: A byte request (size code 0) makes exactly one byte access (bus size code 0) at the request address, whatever that address is.
- R2: A word request (size code 1) at an even address makes one word access (bus size code 1). At an odd address it makes two byte accesses.
- R3: A longword request (size code 2) at an address with low bits 00 makes one longword access (bus size code 2). At low bits 10 it makes two word accesses.
- R4: A longword request at an odd address makes exactly three accesses, in the size order byte, word, byte.
- R5: The address of each piece equals the start address plus the bytes already moved. Pieces are issued in ascending address order, and the next piece appears only after the current one is acknowledged.
- R6: While an access waits for its acknowledge, the request, address, size, direction and write data on the bus stay constant.
- R7: Lanes are big-endian. The byte at address a uses bus bits [8*(3-a[1:0])+7 : 8*(3-a[1:0])]. A word at an even address a uses bits [16*(1-a[1])+15 : 16*(1-a[1])]. On a write, every lane outside the current piece is driven to zero.
- R8: A read returns the assembled value on rdata_o, right-aligned, with the byte at the start address as the most significant byte. A write stores the value in memory in that same byte order.
- R9: done_o is high for exactly one cycle, in the cycle after the final acknowledge. rdata_o holds the read result in that cycle.
- R10: A request raised while the block is busy is ignored and does not change the access sequence.
- R11: While rst_ni is low, bus_req_o, done_o and busy_o are low.
- R12: Every access is aligned. A word access never uses an odd address, and a longword access always uses an address with low bits 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, taken only while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Start address |
| req_size_i | input | 2 | 0 byte, 1 word, 2 longword |
| req_wdata_i | input | 32 | Write value, right-aligned |
| busy_o | output | 1 | A transfer is in progress |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | AW | Access address |
| bus_size_o | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 32 | Lane-placed read data, sampled with acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read value, right-aligned |

## Verification
The assertions take for granted that bus_ack_i is raised only while bus_req_o is high and applies to one access only, and that req_size_i never carries code 3. The bench's bus responder acknowledges only an access it can see as pending, after a chosen number of wait cycles. Every request it issues uses one of the three legal size codes. Start addresses stay inside the modelled memory, so no piece wraps.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int NLANE = 4;
  localparam int DW    = 8 * NLANE;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2} xs_size_e;

  function automatic logic [2:0] nbytes(xs_size_e sz);
    case (sz)
      SZ_W:    return 3'd2;
      SZ_L:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // size of piece idx for a transfer of size sz starting at low bits a
  function automatic xs_size_e piece_size(xs_size_e sz, logic [1:0] a, logic [1:0] idx);
    case (sz)
      SZ_W:    return a[0] ? SZ_B : SZ_W;
      SZ_L:    return a[0] ? ((idx == 2'd1) ? SZ_W : SZ_B) : (a[1] ? SZ_W : SZ_L);
      default: return SZ_B;
    endcase
  endfunction

  function automatic logic [1:0] piece_count(xs_size_e sz, logic [1:0] a);
    case (sz)
      SZ_W:    return a[0] ? 2'd2 : 2'd1;
      SZ_L:    return a[0] ? 2'd3 : (a[1] ? 2'd2 : 2'd1);
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/xs_planner.sv
module xs_planner
  import xs_pkg::*;
(
  input  xs_size_e   size_i,
  input  logic [1:0] start_lo_i,
  input  logic [1:0] idx_i,
  output xs_size_e   piece_sz_o,
  output logic       last_o
);
  logic [1:0] cnt;
  always_comb begin
    cnt        = piece_count(size_i, start_lo_i);
    piece_sz_o = piece_size(size_i, start_lo_i, idx_i);
    last_o     = (idx_i == cnt - 2'd1);
  end
endmodule

// File: rtl/xs_lanes.sv
module xs_lanes
  import xs_pkg::*;
(
  input  logic [1:0]    addr_lo_i,
  input  xs_size_e      piece_sz_i,
  input  logic [DW-1:0] wpiece_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] rpiece_o
);
  logic [2:0]    n;
  logic [2:0]    sh;
  logic [1:0]    lo_lane;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] shifted;

  always_comb begin
    n       = nbytes(piece_sz_i);
    sh      = 3'd4 - {1'b0, addr_lo_i} - n;  // lowest lane used, big-endian
    lo_lane = sh[1:0];
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic act;
    assign act = (3'(l) >= {1'b0, lo_lane}) && (3'(l) < {1'b0, lo_lane} + n);
    assign lane_mask[8*l +: 8] = {8{act}};
  end

  always_comb begin
    shifted     = wpiece_i << {lo_lane, 3'b000};
    bus_wdata_o = shifted & lane_mask;
    rpiece_o    = (bus_rdata_i & lane_mask) >> {lo_lane, 3'b000};
  end
endmodule

// File: rtl/xs_seq.sv
module xs_seq
  import xs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  xs_size_e      req_size_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          bus_ack_i,
  input  xs_size_e      piece_sz_i,
  input  logic          last_i,
  input  logic [DW-1:0] rpiece_i,
  output logic          busy_o,
  output xs_size_e      size_o,
  output logic [1:0]    start_lo_o,
  output logic [1:0]    idx_o,
  output logic          we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] wpiece_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic          busy_q, we_q, done_q;
  xs_size_e      size_q;
  logic [AW-1:0] start_q;
  logic [DW-1:0] wdata_q, acc_q, rdata_q, acc_nxt;
  logic [2:0]    off_q, rem;
  logic [1:0]    idx_q;

  always_comb begin
    rem      = nbytes(size_q) - off_q - nbytes(piece_sz_i);
    wpiece_o = wdata_q >> {rem, 3'b000};
    acc_nxt  = (acc_q << {nbytes(piece_sz_i), 3'b000}) | rpiece_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      size_q  <= SZ_B;
      start_q <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      off_q   <= '0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q  <= 1'b1;
          we_q    <= req_write_i;
          size_q  <= req_size_i;
          start_q <= req_addr_i;
          wdata_q <= req_wdata_i;
          acc_q   <= '0;
          off_q   <= '0;
          idx_q   <= '0;
        end
      end else if (bus_ack_i) begin
        acc_q <= acc_nxt;
        off_q <= off_q + nbytes(piece_sz_i);
        idx_q <= idx_q + 2'd1;
        if (last_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!we_q) rdata_q <= acc_nxt;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign size_o     = size_q;
  assign start_lo_o = start_q[1:0];
  assign idx_o      = idx_q;
  assign we_o       = we_q;
  assign bus_addr_o = start_q + AW'(off_q);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [31:0]   req_wdata_i,
  output logic          busy_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [31:0]   bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [31:0]   bus_rdata_i,
  output logic          done_o,
  output logic [31:0]   rdata_o
);
  xs_size_e      size_q, piece_sz;
  logic [1:0]    start_lo, idx;
  logic          last;
  logic [DW-1:0] wpiece, rpiece;

  xs_planner u_plan (
    .size_i    (size_q),
    .start_lo_i(start_lo),
    .idx_i     (idx),
    .piece_sz_o(piece_sz),
    .last_o    (last)
  );

  xs_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_size_i (xs_size_e'(req_size_i)),
    .req_wdata_i(req_wdata_i),
    .bus_ack_i  (bus_ack_i),
    .piece_sz_i (piece_sz),
    .last_i     (last),
    .rpiece_i   (rpiece),
    .busy_o     (busy_o),
    .size_o     (size_q),
    .start_lo_o (start_lo),
    .idx_o      (idx),
    .we_o       (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .wpiece_o   (wpiece),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
  );

  xs_lanes u_lanes (
    .addr_lo_i  (bus_addr_o[1:0]),
    .piece_sz_i (piece_sz),
    .wpiece_i   (wpiece),
    .bus_rdata_i(bus_rdata_i),
    .bus_wdata_o(bus_wdata_o),
    .rpiece_o   (rpiece)
  );

  assign bus_req_o  = busy_o;
  assign bus_size_o = piece_sz;
endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_size_o,
  input logic [31:0]   bus_wdata_o,
  input logic          bus_ack_i,
  input logic          done_o,
  input logic          busy_o
);
  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_req_o && !done_o && !busy_o);

  p_aligned_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_size_o != 2'd3) &&
                  !(bus_size_o == 2'd1 && bus_addr_o[0]) &&
                  !(bus_size_o == 2'd2 && bus_addr_o[1:0] != 2'b00));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_size_o)
                                && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_next_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o ||
      (bus_addr_o == $past(bus_addr_o) + (AW'(1) << $past(bus_size_o))));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o && bus_ack_i) && !bus_req_o);
endmodule

bind xfer_splitter xs_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_size_o (bus_size_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_ack_i  (bus_ack_i),
  .done_o     (done_o),
  .busy_o     (busy_o)
);

// File: tb/tb_xfer_splitter.sv
`timescale 1ns/1ps
module tb_xfer_splitter;
  localparam int AW = 32;

  logic          clk_i = 0, rst_ni = 0;
  logic          req_i = 0, req_write_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_size_i = '0;
  logic [31:0]   req_wdata_i = '0;
  logic          busy_o, bus_req_o, bus_we_o, done_o;
  logic [AW-1:0] bus_addr_o;
  logic [1:0]    bus_size_o;
  logic [31:0]   bus_wdata_o, rdata_o;
  logic          bus_ack_i = 0;
  logic [31:0]   bus_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  xfer_splitter #(.AW(AW)) dut (.*);

  int errors = 0, checks = 0;
  logic [7:0]    mem [0:63];
  int            lat = 0;
  int            log_cnt = 0;
  logic [AW-1:0] log_addr [0:7];
  logic [1:0]    log_size [0:7];
  int            lane_bad = 0;
  int            extra_dones = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder
  initial begin
    int waitc = 0;
    forever begin
      @(negedge clk_i);
      bus_ack_i = 0;
      if (bus_req_o) begin
        if (waitc >= lat) begin
          int n, lo;
          logic [5:0] base;
          waitc = 0;
          n  = 1 << bus_size_o;
          lo = 4 - int'(bus_addr_o[1:0]) - n;
          base = {bus_addr_o[5:2], 2'b00};
          for (int l = 0; l < 4; l++) bus_rdata_i[8*l +: 8] = mem[base + 6'(3 - l)];
          if (log_cnt < 8) begin
            log_addr[log_cnt] = bus_addr_o;
            log_size[log_cnt] = bus_size_o;
          end
          log_cnt++;
          if (bus_we_o) begin
            for (int l = 0; l < 4; l++)
              if ((l < lo || l >= lo + n) && bus_wdata_o[8*l +: 8] != 8'h00) lane_bad++;
            for (int k = 0; k < n; k++)
              mem[6'(bus_addr_o) + 6'(k)] = bus_wdata_o[8*(3 - int'(bus_addr_o[1:0]) - k) +: 8];
          end
          bus_ack_i = 1;
        end else waitc++;
      end else waitc = 0;
    end
  end

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  function automatic logic [31:0] mem_val(int a, int nb);
    logic [31:0] v = '0;
    for (int k = 0; k < nb; k++) v = (v << 8) | 32'(mem[a + k]);
    return v;
  endfunction

  // run one transfer and check division, addresses, data and done
  task automatic xfer(input string req, input bit wr, input int a, input int sz,
                      input logic [31:0] val, input int exp_n,
                      input int s0, input int s1, input int s2);
    int nb = 1 << sz;
    int cyc = 0;
    int off = 0;
    int exps [3];
    logic [31:0] exp_rd;
    exps[0] = s0; exps[1] = s1; exps[2] = s2;
    fill_mem();
    exp_rd = mem_val(a, nb);
    log_cnt = 0; lane_bad = 0;
    @(negedge clk_i);
    req_i = 1; req_write_i = wr; req_addr_i = AW'(a); req_size_i = 2'(sz); req_wdata_i = val;
    @(negedge clk_i);
    req_i = 0;
    while (!done_o && cyc < 100) begin @(negedge clk_i); cyc++; end
    chk(done_o, {req, " R9 done"}, 64'(done_o), 1);
    chk(log_cnt == exp_n, {req, " piece count R1 R2 R3 R4"}, 64'(log_cnt), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_cnt; i++) begin
      chk(log_size[i] == 2'(exps[i]), {req, " piece size R1 R2 R3 R4"}, 64'(log_size[i]), 64'(exps[i]));
      chk(log_addr[i] == AW'(a + off), {req, " piece addr R5"}, 64'(log_addr[i]), 64'(a + off));
      off += 1 << exps[i];
    end
    if (wr) begin
      chk(mem_val(a, nb) == (val & ((nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 1))),
          {req, " write bytes R8"}, 64'(mem_val(a, nb)), 64'(val));
      chk(lane_bad == 0, {req, " idle lanes zero R7"}, 64'(lane_bad), 0);
    end else
      chk(rdata_o == exp_rd, {req, " read value R8 R7"}, 64'(rdata_o), 64'(exp_rd));
    @(negedge clk_i);
    chk(!done_o, {req, " done one cycle R9"}, 64'(done_o), 0);
  endtask

  task automatic t_reset();
    chk(!bus_req_o && !done_o && !busy_o, "reset quiet R11",
        64'({bus_req_o, done_o, busy_o}), 0);
  endtask

  task automatic t_byte();
    xfer("byte rd odd", 0, 5, 0, 0, 1, 0, 0, 0);   // R1
    xfer("byte wr", 1, 10, 0, 32'hA5, 1, 0, 0, 0);  // R1
  endtask

  task automatic t_word();
    xfer("word rd even", 0, 8, 1, 0, 1, 1, 0, 0);        // R2
    xfer("word wr odd", 1, 13, 1, 32'hBEEF, 2, 0, 0, 0); // R2
    xfer("word rd odd", 0, 7, 1, 0, 2, 0, 0, 0);         // R2
  endtask

  task automatic t_long();
    xfer("long rd 4n", 0, 16, 2, 0, 1, 2, 0, 0);                 // R3
    xfer("long wr 4n+2", 1, 18, 2, 32'h1234_5678, 2, 1, 1, 0);   // R3
    xfer("long rd 4n+1", 0, 21, 2, 0, 3, 0, 1, 0);               // R4
    xfer("long wr 4n+3", 1, 27, 2, 32'hCAFE_F00D, 3, 0, 1, 0);   // R4
    xfer("long rd 4n+3", 0, 35, 2, 0, 3, 0, 1, 0);               // R4
  endtask

  task automatic t_wait_states();
    lat = 2;  // R6: access held through wait states
    xfer("long wr wait", 1, 41, 2, 32'h0BAD_CAFE, 3, 0, 1, 0);
    xfer("word rd wait", 0, 45, 1, 0, 2, 0, 0, 0);
    lat = 0;
  endtask

  task automatic t_busy_ignore();
    int cyc = 0;
    fill_mem();
    lat = 1; log_cnt = 0;
    @(negedge clk_i);
    req_i = 1; req_write_i = 0; req_addr_i = 32'd49; req_size_i = 2'd2;
    @(negedge clk_i);
    req_addr_i = 32'd4; req_size_i = 2'd0;  // held high while busy: R10
    repeat (2) @(negedge clk_i);
    req_i = 0;
    while (!done_o && cyc < 100) begin @(negedge clk_i); cyc++; end
    chk(rdata_o == mem_val(49, 4), "busy ignore value R10", 64'(rdata_o), 64'(mem_val(49, 4)));
    chk(log_cnt == 3 && log_addr[0] == 32'd49, "busy ignore pieces R10", 64'(log_cnt), 3);
    repeat (3) @(negedge clk_i);
    chk(!bus_req_o && log_cnt == 3, "no access after done R10", 64'(log_cnt), 3);
    lat = 0;
  endtask

  initial begin
    fill_mem();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_byte();
    t_word();
    t_long();
    t_wait_states();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) if (done_o && bus_req_o) extra_dones++;
endmodule